// File: doc/BRIEF.md
# Centisecond Stopwatch with Seven-Segment Outputs

This block measures elapsed time in hundredths of a second and shows it on six seven-segment digits arranged as minutes, seconds and hundredths (MM:SS.hh). A down-counting divider turns the system clock into a one-cycle enable every `TICK_CYCLES` clocks. With the default of 500,000 cycles at 50 MHz, this is one enable every 10 ms. The enable advances a chain of six small decimal or base-six digit counters. Each digit feeds its own segment decoder.

Three active-low pushbutton inputs control the block. Start sets it running. Stop freezes the digits and the divider together, so the shown value is kept. Clear forces everything back to zero at once. The inputs are assumed to be already debounced and synchronous to the clock. The `MT_MAX` parameter sets the largest value of the minutes-tens digit, which is 5 by default. A smaller value shortens the full span, which speeds up verification of the wrap.

Top module: `cs_stopwatch`

## Requirements
- R1: While `rst_ni` is low, or while `clear_ni` is low, all six digits read 0 at once, without waiting for a clock edge. The run state is stopped and the divider is reloaded with `TICK_CYCLES-1`.
- R2: The run state becomes set on the first rising edge at which `start_ni` is low. From a cleared state, the first increment occurs exactly `TICK_CYCLES` edges after that edge.
- R3: While running, the time value grows by exactly one hundredth every `TICK_CYCLES` clock edges. The internal enable is never high for two consecutive cycles.
- R4: A low `stop_ni` sampled at an edge stops the run state, and stop wins over a simultaneous start. While stopped, both the digits and the divider hold, so after a restart the divider resumes its remaining count.
- R5: The digits, from least to most significant, are: hundredths units (0-9), tenths (0-9), seconds units (0-9), seconds tens (0-5), minutes units (0-9) and minutes tens (0-`MT_MAX`). A digit advances only on an enable while every lower digit is at its maximum. It wraps to 0 in the same cycle as it carries.
- R6: After the last value (59:59.99 with the defaults), the next enable returns all digits to 0.
- R7: The segment outputs are active low, with bit 0 = a through bit 6 = g. The patterns are, in hex: 0=40, 1=79, 2=24, 3=30, 4=19, 5=12, 6=02, 7=78, 8=00, 9=10. `seg0_o` carries the hundredths units and `seg5_o` the minutes tens.
- R8: While `clear_ni` is low, a low `start_ni` has no effect, and the display stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| start_ni | input | 1 | Start button, active low |
| stop_ni | input | 1 | Stop button, active low |
| clear_ni | input | 1 | Clear button, active low, asynchronous to the counters |
| seg0_o | output | 7 | Hundredths units segments, active low |
| seg1_o | output | 7 | Tenths segments, active low |
| seg2_o | output | 7 | Seconds units segments, active low |
| seg3_o | output | 7 | Seconds tens segments, active low |
| seg4_o | output | 7 | Minutes units segments, active low |
| seg5_o | output | 7 | Minutes tens segments, active low |

## Verification
The assertions check the following on every cycle:
- Each digit stays within its radix, holds without an enable and wraps to zero when it carries.
- The enable never lasts two cycles and never appears while stopped.
- The divider count holds while stopped.
- The full-span wrap returns all digits to zero.

Only the bench scenarios can show the points that need exact timing or the ports. These are the exact number of edges from start to the first increment, the extra increment taken when stop arrives on an enable cycle, and the divider resuming mid-count. They also include the segment patterns at the ports and the immediate effect of clear. The bench covers them by comparing against a behavioural time model on every clock.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int unsigned NUM_DIGITS = 6;
  typedef logic [3:0] digit_t;
  typedef logic [6:0] seg_t;

  // Largest value of digit idx; idx 5 is the minutes tens.
  function automatic int unsigned digit_max(int unsigned idx, int unsigned mt_max);
    if (idx == 3) return 5;
    if (idx == 5) return mt_max;
    return 9;
  endfunction
endpackage

// File: rtl/sw_tick_div.sv
module sw_tick_div #(
  parameter int unsigned TICK_CYCLES = 500000  // must be >= 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(TICK_CYCLES);
  localparam logic [CW-1:0] RELOAD = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= RELOAD;
    else if (run_i) cnt_q <= (cnt_q == '0) ? RELOAD : cnt_q - 1'b1;
  end

  assign tick_o = run_i && (cnt_q == '0);

  // R3
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  // R4
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_q));
endmodule

// File: rtl/sw_digit.sv
module sw_digit
  import sw_pkg::*;
#(
  parameter int unsigned MAX_VAL = 9
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  output digit_t val_o,
  output logic   max_o
);
  localparam digit_t MAXV = digit_t'(MAX_VAL);

  digit_t val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   val_q <= '0;
    else if (en_i) val_q <= max_o ? '0 : val_q + 1'b1;
  end

  assign val_o = val_q;
  assign max_o = (val_q == MAXV);

  // R5
  digit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    val_q <= MAXV);
  // R5
  digit_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && val_q == MAXV) |=> val_q == '0);
  // R5
  digit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(val_q));
endmodule

// File: rtl/sw_seg7.sv
module sw_seg7
  import sw_pkg::*;
(
  input  digit_t digit_i,
  output seg_t   seg_o
);
  seg_t on;  // active-high, bit0 = a

  always_comb begin
    unique case (digit_i)
      4'd0: on = 7'b0111111;
      4'd1: on = 7'b0000110;
      4'd2: on = 7'b1011011;
      4'd3: on = 7'b1001111;
      4'd4: on = 7'b1100110;
      4'd5: on = 7'b1101101;
      4'd6: on = 7'b1111101;
      4'd7: on = 7'b0000111;
      4'd8: on = 7'b1111111;
      4'd9: on = 7'b1101111;
      default: on = 7'b0000000;
    endcase
  end

  assign seg_o = ~on;
endmodule

// File: rtl/cs_stopwatch.sv
module cs_stopwatch
  import sw_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 500000,
  parameter int unsigned MT_MAX      = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_ni,
  input  logic       stop_ni,
  input  logic       clear_ni,
  output logic [6:0] seg0_o,
  output logic [6:0] seg1_o,
  output logic [6:0] seg2_o,
  output logic [6:0] seg3_o,
  output logic [6:0] seg4_o,
  output logic [6:0] seg5_o
);
  logic   core_rst_n;
  logic   run_q;
  logic   tick;
  logic   en   [NUM_DIGITS];
  logic   at_max [NUM_DIGITS];
  digit_t val  [NUM_DIGITS];
  seg_t   seg  [NUM_DIGITS];

  // clear acts as the counters' asynchronous reset
  assign core_rst_n = rst_ni & clear_ni;

  always_ff @(posedge clk_i or negedge core_rst_n) begin
    if (!core_rst_n)    run_q <= 1'b0;
    else if (!stop_ni)  run_q <= 1'b0;
    else if (!start_ni) run_q <= 1'b1;
  end

  sw_tick_div #(.TICK_CYCLES(TICK_CYCLES)) u_div (
    .clk_i (clk_i),
    .rst_ni(core_rst_n),
    .run_i (run_q),
    .tick_o(tick)
  );

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
    if (i == 0) begin : g_first
      assign en[i] = tick;
    end else begin : g_chain
      assign en[i] = en[i-1] & at_max[i-1];
    end

    sw_digit #(.MAX_VAL(digit_max(i, MT_MAX))) u_digit (
      .clk_i (clk_i),
      .rst_ni(core_rst_n),
      .en_i  (en[i]),
      .val_o (val[i]),
      .max_o (at_max[i])
    );

    sw_seg7 u_seg (
      .digit_i(val[i]),
      .seg_o  (seg[i])
    );
  end

  assign seg0_o = seg[0];
  assign seg1_o = seg[1];
  assign seg2_o = seg[2];
  assign seg3_o = seg[3];
  assign seg4_o = seg[4];
  assign seg5_o = seg[5];

  // R4
  idle_no_tick_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    !run_q |-> !tick);
  // R6
  span_wrap_chk: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    (tick && at_max[0] && at_max[1] && at_max[2] && at_max[3] && at_max[4] && at_max[5])
    |=> (val[0] == '0 && val[1] == '0 && val[2] == '0 &&
         val[3] == '0 && val[4] == '0 && val[5] == '0));
  // R1
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_ni |-> (seg[0] == 7'h40 && !run_q));
endmodule

// File: tb/sim_cs_stopwatch.sv
module sim_cs_stopwatch;
  localparam int unsigned TICK   = 2;
  localparam int unsigned MTMAX  = 0;
  localparam int          LIMIT  = 60000 * (MTMAX + 1);
  localparam int          WDOG   = 180000;

  logic clk = 1'b0;
  logic rst_n = 1'b0, start_n = 1'b1, stop_n = 1'b1, clear_n = 1'b1;
  logic [6:0] s0, s1, s2, s3, s4, s5;

  int checks = 0, errors = 0, cycles = 0;
  int m_time = 0, m_div = TICK - 1;
  bit m_run = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cs_stopwatch #(.TICK_CYCLES(TICK), .MT_MAX(MTMAX)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_ni(start_n), .stop_ni(stop_n),
    .clear_ni(clear_n), .seg0_o(s0), .seg1_o(s1), .seg2_o(s2),
    .seg3_o(s3), .seg4_o(s4), .seg5_o(s5));

  // active-low patterns as listed in R7
  function automatic logic [6:0] enc(int d);
    case (d)
      0: return 7'h40; 1: return 7'h79; 2: return 7'h24; 3: return 7'h30;
      4: return 7'h19; 5: return 7'h12; 6: return 7'h02; 7: return 7'h78;
      8: return 7'h00; 9: return 7'h10;
      default: return 7'h7f;
    endcase
  endfunction

  function automatic logic [41:0] show(int t);
    return {enc((t / 60000) % (MTMAX + 1)), enc((t / 6000) % 10),
            enc((t / 1000) % 6), enc((t / 100) % 10),
            enc((t / 10) % 10), enc(t % 10)};
  endfunction

  task automatic check_time(int exp_t, string tag);
    logic [41:0] act;
    act = {s5, s4, s3, s2, s1, s0};
    checks++;
    if (act !== show(exp_t)) begin
      errors++;
      $display("FAIL %s: segs=%h expected=%h (time %0d)", tag, act, show(exp_t), exp_t);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // behavioural reference, stepped on each rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n || !clear_n) begin
      m_run = 1'b0; m_div = TICK - 1; m_time = 0;
    end else begin
      if (m_run && m_div == 0) m_time = (m_time + 1) % LIMIT;
      if (m_run) m_div = (m_div == 0) ? TICK - 1 : m_div - 1;
      if (!stop_n) m_run = 1'b0;
      else if (!start_n) m_run = 1'b1;
    end
    #1;
    if (rst_n && !done) check_time(m_time, "R5 model");
  end

  initial begin
    wait (cycles >= WDOG);
    errors++;
    $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic pulse_start();
    start_n = 1'b0; @(negedge clk); start_n = 1'b1;
  endtask

  initial begin
    wait_n(3);
    check_time(0, "R1 reset");
    rst_n = 1'b1;
    wait_n(5);
    check_time(0, "R2 idle without start");

    pulse_start();                 // start sampled at edge k
    wait_n(1); check_time(0, "R2 before first tick");
    wait_n(1); check_time(1, "R2 first tick");
    wait_n(23); check_time(12, "R3 rate");
    checks++;
    if (s0 !== 7'h24) begin
      errors++; $display("FAIL R7: seg0=%h expected=24", s0);
    end

    stop_n = 1'b0; @(negedge clk); stop_n = 1'b1;  // stop lands on a tick cycle
    wait_n(10); check_time(13, "R4 frozen");
    pulse_start();
    wait_n(1); check_time(13, "R4 restart");
    wait_n(1); check_time(14, "R4 restart tick");

    stop_n = 1'b0; start_n = 1'b0; @(negedge clk);
    stop_n = 1'b1; start_n = 1'b1;
    wait_n(5); check_time(14, "R4 stop wins");
    pulse_start();
    wait_n(1); check_time(15, "R4 divider resumes mid-count");

    wait_n(7);
    clear_n = 1'b0; #1;
    check_time(0, "R1 clear immediate");
    start_n = 1'b0;
    @(negedge clk);
    wait_n(3); check_time(0, "R8 start ignored under clear");
    clear_n = 1'b1; start_n = 1'b1;
    wait_n(4); check_time(0, "R8 still stopped after clear");

    pulse_start();
    wait_n(200);    check_time(100, "R5 tenths carry");
    wait_n(1800);   check_time(1000, "R5 seconds carry");
    wait_n(10000);  check_time(6000, "R5 seconds tens wrap");
    wait_n(107999); check_time(LIMIT - 1, "R6 last value");
    wait_n(1);      check_time(0, "R6 wrap to zero");
    wait_n(2);      check_time(1, "R6 counting after wrap");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule